// File: doc/BRIEF.md
# Serial EEPROM Slave Write Receiver

This block is the bus-facing write path of a small serial EEPROM. It watches the two-wire clock and data lines, passes both through a two-stage synchronizer, recognises START and STOP conditions on the synchronized samples, and shifts in the bytes of a write transfer. The first byte names the device: a fixed device code, a set of chip-select bits that must match the strap inputs, and a direction bit. The second byte is the word address. Every byte after that is a data byte.

Each accepted byte is acknowledged by pulling the data line low through an open-drain output enable. The storage side receives the word address, one valid strobe per data byte, and a one-cycle commit pulse when a STOP ends a transfer that carried data. While the storage side reports busy, the block does not acknowledge any control byte, so the master can poll until the write cycle has finished.

Top module: `eeprom_wr_front`

## Requirements
- R1: START (data falling while clock high) and STOP (data rising while clock high) are recognised. A control byte carrying device code `DEV_CODE`, chip-select bits [3:1] equal to `chipSel` and bit 0 equal to 0 is acknowledged.
- R2: A control byte whose upper four bits differ from `DEV_CODE` gets no acknowledge. Every later byte up to the next START is also left unacknowledged and produces no `wrValid`.
- R3: A control byte whose bits [3:1] differ from `chipSel` gets no acknowledge.
- R4: A control byte with bit 0 equal to 1 (a read request) gets no acknowledge.
- R5: The byte after an accepted control byte is acknowledged and appears on `wordAddr`. Bytes are received most significant bit first.
- R6: Each byte after the word address is acknowledged and produces one single-cycle `wrValid` pulse, with the byte on `wrData` in that same cycle.
- R7: A STOP after at least one data byte gives exactly one single-cycle `commit` pulse. A STOP with no data byte gives none.
- R8: While `busy` is high, a control byte is not acknowledged.
- R9: `sdaOe` is low at all times except during the acknowledge bit. That bit is driven from the clock fall after the eighth bit until the clock fall after the ninth.
- R10: A repeated START in the middle of a transfer drops it without a `commit` and begins a new control byte.
- R11: After reset, `sdaOe`, `wrValid` and `commit` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as received |
| sdaIn | input | 1 | Bus data line as received |
| chipSel | input | 3 | Chip-select straps |
| busy | input | 1 | Storage write cycle in progress |
| sdaOe | output | 1 | Pull data line low (acknowledge) |
| wordAddr | output | 8 | Word address of the current transfer |
| wrData | output | 8 | Received data byte |
| wrValid | output | 1 | One-cycle strobe for `wrData` |
| commit | output | 1 | One-cycle pulse starting the write cycle |

## Verification
The hardest situation to reach is a repeated START that arrives after data bytes have already been accepted. The data line must rise while the clock is low and then fall while the clock is high, in the middle of a transfer. The bench has a dedicated directed sequence for this. It then follows with a complete transfer and checks that only that transfer produces a commit. Randomised transfers, built from a fixed seed, mix matching and non-matching control bytes, busy states and data counts from zero upward, so that both the silent paths and the acknowledged paths are taken many times.

// File: rtl/eewr_pkg.sv
package eewr_pkg;
  typedef struct packed {
    logic startEv;
    logic stopEv;
    logic sclRise;
    logic sclFall;
  } busEv_t;

  typedef struct packed {
    logic shiftEn;
    logic loadAddr;
    logic pushData;
    logic ackSet;
    logic ackClr;
  } dpCmd_t;

  typedef enum logic [1:0] {ST_IDLE, ST_CTRL, ST_ADDR, ST_DATA} rxState_t;
endpackage

// File: rtl/eewr_dp.sv
module eewr_dp
  import eewr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCmd_t            cmd,
  output busEv_t            ev,
  output logic [BYTE_W-1:0] rxByte,
  output logic              sdaOe,
  output logic [BYTE_W-1:0] wordAddr,
  output logic [BYTE_W-1:0] wrData
);
  logic [1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;
  logic sclNow, sdaNow;

  assign sclNow = sclSync[1];
  assign sdaNow = sdaSync[1];

  // Idle bus is high; reset to that level so no event fires at release.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  always_comb begin
    ev.sclRise = sclNow & ~sclPrev;
    ev.sclFall = ~sclNow & sclPrev;
    ev.startEv = sclNow & sclPrev & sdaPrev & ~sdaNow;
    ev.stopEv  = sclNow & sclPrev & ~sdaPrev & sdaNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte   <= '0;
      wordAddr <= '0;
      wrData   <= '0;
      sdaOe    <= 1'b0;
    end else begin
      if (cmd.shiftEn)  rxByte   <= {rxByte[BYTE_W-2:0], sdaNow};
      if (cmd.loadAddr) wordAddr <= rxByte;
      if (cmd.pushData) wrData   <= rxByte;
      if (cmd.ackClr)      sdaOe <= 1'b0;
      else if (cmd.ackSet) sdaOe <= 1'b1;
    end
  end
endmodule

// File: rtl/eewr_ctrl.sv
module eewr_ctrl
  import eewr_pkg::*;
#(
  parameter int          DEV_W    = 4,
  parameter int          CS_W     = 3,
  parameter [DEV_W-1:0]  DEV_CODE = 4'b1010
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  busEv_t                      ev,
  input  logic [DEV_W+CS_W:0]         rxByte,
  input  logic [CS_W-1:0]             chipSel,
  input  logic                        busy,
  output dpCmd_t                      cmd,
  output logic                        wrValid,
  output logic                        commit
);
  localparam int BYTE_W = DEV_W + CS_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  rxState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic inAck, gotData;
  logic byteFull, decide, ctrlOk, accept;

  always_comb begin
    byteFull = (bitCnt == CNT_W'(BYTE_W));
    decide   = ev.sclFall && byteFull && !inAck && (state != ST_IDLE);
    ctrlOk   = (rxByte[BYTE_W-1 -: DEV_W] == DEV_CODE) &&
               (rxByte[CS_W:1] == chipSel) && !rxByte[0] && !busy;
    accept   = decide && ((state != ST_CTRL) || ctrlOk);

    cmd          = '0;
    cmd.shiftEn  = ev.sclRise && (state != ST_IDLE) && !byteFull && !inAck;
    cmd.loadAddr = accept && (state == ST_ADDR);
    cmd.pushData = accept && (state == ST_DATA);
    cmd.ackSet   = accept;
    cmd.ackClr   = (ev.sclFall && inAck) || ev.startEv || ev.stopEv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      inAck   <= 1'b0;
      gotData <= 1'b0;
      wrValid <= 1'b0;
      commit  <= 1'b0;
    end else begin
      wrValid <= cmd.pushData;
      commit  <= ev.stopEv && (state == ST_DATA) && gotData;
      if (ev.startEv) begin
        state   <= ST_CTRL;
        bitCnt  <= '0;
        inAck   <= 1'b0;
        gotData <= 1'b0;
      end else if (ev.stopEv) begin
        state   <= ST_IDLE;
        bitCnt  <= '0;
        inAck   <= 1'b0;
        gotData <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (cmd.shiftEn) bitCnt <= bitCnt + 1'b1;
        if (decide) begin
          if (accept) begin
            inAck <= 1'b1;
            unique case (state)
              ST_CTRL: state <= ST_ADDR;
              ST_ADDR: state <= ST_DATA;
              default: gotData <= 1'b1;
            endcase
          end else begin
            state  <= ST_IDLE;
            bitCnt <= '0;
          end
        end else if (ev.sclFall && inAck) begin
          inAck  <= 1'b0;
          bitCnt <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_wr_front.sv
module eeprom_wr_front
  import eewr_pkg::*;
#(
  parameter int               DEV_W    = 4,
  parameter int               CS_W     = 3,
  parameter logic [DEV_W-1:0] DEV_CODE = 4'b1010
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sclIn,
  input  logic                    sdaIn,
  input  logic [CS_W-1:0]         chipSel,
  input  logic                    busy,
  output logic                    sdaOe,
  output logic [DEV_W+CS_W:0]     wordAddr,
  output logic [DEV_W+CS_W:0]     wrData,
  output logic                    wrValid,
  output logic                    commit
);
  localparam int BYTE_W = DEV_W + CS_W + 1;

  busEv_t ev;
  dpCmd_t cmd;
  logic [BYTE_W-1:0] rxByte;

  eewr_dp #(.BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .cmd(cmd),
    .ev(ev), .rxByte(rxByte), .sdaOe(sdaOe), .wordAddr(wordAddr),
    .wrData(wrData)
  );

  eewr_ctrl #(.DEV_W(DEV_W), .CS_W(CS_W), .DEV_CODE(DEV_CODE)) u_ctrl (
    .clk(clk), .rstN(rstN), .ev(ev), .rxByte(rxByte), .chipSel(chipSel),
    .busy(busy), .cmd(cmd), .wrValid(wrValid), .commit(commit)
  );
endmodule

// File: rtl/eewr_chk.sv
module eewr_chk
  import eewr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input busEv_t            ev,
  input logic              sdaOe,
  input logic              wrValid,
  input logic              commit,
  input logic [BYTE_W-1:0] wordAddr
);
  // R6: data strobe lasts exactly one cycle
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !wrValid);

  // R7: commit lasts one cycle and follows a STOP
  assert_commit_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> !commit);
  assert_commit_after_stop_R7: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> $past(ev.stopEv));

  // R9: acknowledge drive begins only on a clock fall
  assert_ack_on_fall_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> $past(ev.sclFall));
  assert_ack_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaOe) |-> $past(ev.sclFall || ev.startEv || ev.stopEv));

  // R5: address register moves only on the decision edge
  assert_addr_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wordAddr) |-> $past(ev.sclFall));
endmodule

bind eeprom_wr_front eewr_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .ev(ev), .sdaOe(sdaOe), .wrValid(wrValid),
  .commit(commit), .wordAddr(wordAddr)
);

// File: tb/sim_eeprom_wr_front.sv
module sim_eeprom_wr_front;
  localparam int Q = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic sclIn = 1'b1, sdaIn = 1'b1, busy = 1'b0;
  logic [2:0] chipSel = 3'b101;
  logic sdaOe, wrValid, commit;
  logic [7:0] wordAddr, wrData;

  int checks = 0, failures = 0;
  int capN = 0, commitN = 0;
  logic [7:0] capLast = '0;

  always #10 clk = ~clk;

  eeprom_wr_front u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .chipSel(chipSel),
    .busy(busy), .sdaOe(sdaOe), .wordAddr(wordAddr), .wrData(wrData),
    .wrValid(wrValid), .commit(commit)
  );

  always @(negedge clk) begin
    if (wrValid) begin capLast = wrData; capN++; end
    if (commit) commitN++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic startCond();
    sdaIn = 1'b1; waitQ();
    sclIn = 1'b1; waitQ();
    sdaIn = 1'b0; waitQ();
    sclIn = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    sdaIn = 1'b0; waitQ();
    sclIn = 1'b1; waitQ();
    sdaIn = 1'b1; waitQ();
    waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    bit oeSeen = 0;
    for (int i = 7; i >= 0; i--) begin
      sdaIn = b[i]; waitQ();
      sclIn = 1'b1; waitQ();
      if (sdaOe) oeSeen = 1;
      sclIn = 1'b0; waitQ();
    end
    chk(!oeSeen, "R9 data bits released", oeSeen, 0);
    sdaIn = 1'b1; waitQ();
    sclIn = 1'b1; waitQ();
    ack = sdaOe;
    sclIn = 1'b0; waitQ();
    chk(!sdaOe, "R9 ack released", sdaOe, 0);
  endtask

  function automatic bit expCtrl(input logic [7:0] c, input logic [2:0] cs, input logic bz);
    return (c[7:4] == 4'hA) && (c[3:1] == cs) && !c[0] && !bz;
  endfunction

  function automatic logic [7:0] dataAt(input logic [7:0] s, input int i);
    return s + 8'(i * 37);
  endfunction

  task automatic runWrite(input logic [7:0] ctl, input logic [7:0] addr,
                          input int n, input logic [7:0] seed, input string tag);
    bit ack, e;
    int c0, n0;
    e  = expCtrl(ctl, chipSel, busy);
    c0 = commitN;
    startCond();
    sendByte(ctl, ack);
    chk(ack == e, {tag, " control ack"}, ack, e);
    if (e) begin
      sendByte(addr, ack);
      chk(ack, "R5 address ack", ack, 1);
      chk(wordAddr == addr, "R5 wordAddr", wordAddr, addr);
      for (int i = 0; i < n; i++) begin
        n0 = capN;
        sendByte(dataAt(seed, i), ack);
        chk(ack, "R6 data ack", ack, 1);
        chk(capN == n0 + 1, "R6 one strobe", capN - n0, 1);
        chk(capLast == dataAt(seed, i), "R6 wrData", capLast, dataAt(seed, i));
      end
    end else begin
      n0 = capN;
      sendByte(addr, ack);
      chk(!ack, "R2 ignored until START ack", ack, 0);
      chk(capN == n0, "R2 ignored until START strobe", capN - n0, 0);
    end
    stopCond();
    chk(commitN - c0 == ((e && n > 0) ? 1 : 0), "R7 commit count",
        commitN - c0, (e && n > 0) ? 1 : 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit ack;
    int c0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!sdaOe && !wrValid && !commit, "R11 reset outputs", {sdaOe, wrValid, commit}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk(!sdaOe && !wrValid && !commit, "R11 after release", {sdaOe, wrValid, commit}, 0);

    runWrite(8'hAA, 8'h3C, 3, 8'h11, "R1");   // match
    runWrite(8'h9A, 8'h10, 2, 8'h20, "R2");   // wrong device code
    runWrite(8'hA6, 8'h10, 2, 8'h20, "R3");   // wrong chip select
    runWrite(8'hAB, 8'h10, 2, 8'h20, "R4");   // read request
    runWrite(8'hAA, 8'h55, 0, 8'h00, "R7");   // no data, no commit
    runWrite(8'hAA, 8'hFF, 17, 8'hF0, "R6");  // long burst
    busy = 1'b1;
    runWrite(8'hAA, 8'h01, 1, 8'h01, "R8");
    busy = 1'b0;

    // R10: repeated START after two data bytes, then a fresh transfer
    c0 = commitN;
    startCond();
    sendByte(8'hAA, ack);
    sendByte(8'h40, ack);
    sendByte(8'h01, ack);
    sendByte(8'h02, ack);
    startCond();
    chk(commitN == c0, "R10 no commit on restart", commitN - c0, 0);
    sendByte(8'hAA, ack);
    chk(ack, "R10 new control ack", ack, 1);
    sendByte(8'h77, ack);
    chk(wordAddr == 8'h77, "R10 new address", wordAddr, 8'h77);
    sendByte(8'hC3, ack);
    stopCond();
    chk(commitN == c0 + 1, "R10 single commit", commitN - c0, 1);

    for (int t = 0; t < 30; t++) begin
      logic [7:0] ctl;
      chipSel = 3'($urandom_range(0, 7));
      busy    = ($urandom_range(0, 5) == 0);
      ctl     = ($urandom_range(0, 2) != 0) ? {4'hA, chipSel, 1'b0} : 8'($urandom);
      runWrite(ctl, 8'($urandom), $urandom_range(0, 4), 8'($urandom), "R1");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule